// File: doc/BRIEF.md
# Bridge Interrupt Status and Enable Aggregator

This block collects the event and error pulses of a bridge between a system bus and a PCI bus. It keeps them in an 8-bit sticky status register and combines them with an 8-bit enable register into two interrupt outputs. One output is a level interrupt toward the local processor. The other is an active-low interrupt line driven onto the PCI bus. The local processor and the PCI host each have their own register port, and each port has its own access rights.

The sources are the two doorbells, the completion of either DMA direction, a system-bus error, and three PCI error classes. Four fatal causes share one status bit, and two parity causes share another. The PCI doorbell bit is the only one routed to the PCI interrupt line. Every other bit feeds the local interrupt. Both outputs are registered and follow the register contents one clock later.

Each register port has a write strobe, a register select (0 = status, 1 = enable), write data and a combinational read-data bus. Read data is zero-extended to the bus width.

Top module: `bridge_irq_agg`

## Requirements
- R1: While reset is held and on the first clock after it, status and enable read as zero, `cpuIrq` is 0 and `pciIntN` is 1.
- R2: A system-side write with select 1 loads the enable register from data bits 7:0. Bit order, 7 down to 0: PCI doorbell, system doorbell, PCI-to-system DMA done, system-to-PCI DMA done, system-bus error, PCI parity error, PCI fatal error, PCI system error. Bits above 7 read as 0 on both ports and ignore writes.
- R3: A PCI-side write with select 1 leaves the enable register unchanged. The PCI port reads the same enable value as the system port.
- R4: Each event pulse sets its status bit (PCI doorbell 7, system doorbell 6, PCI-to-system DMA done 5, system-to-PCI DMA done 4, system-bus error 3). The bit stays set until it is cleared.
- R5: Status bit 1 is set by any of these: master abort, target abort, TRDY timeout, retry-count timeout.
- R6: Status bit 2 is set by a parity error on a master read, or by PERR# seen during a master write.
- R7: Status bit 0 is set when SERR# is seen asserted.
- R8: A system-side write with select 0 clears every status bit written as 1. Bits written as 0 keep their value.
- R9: A PCI-side write with select 0 clears status bit 7 when data bit 7 is 1. It has no effect on bits 6:0.
- R10: When a set event and a clear reach the same status bit in the same clock, the bit ends set.
- R11: `cpuIrq` is 1 exactly when, one clock earlier, some bit among 6:0 had both status and enable at 1.
- R12: `pciIntN` is 0 exactly when, one clock earlier, status bit 7 and enable bit 7 were both 1. Bit 7 never raises `cpuIrq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pciDoorbellEvt | input | 1 | PCI doorbell event pulse |
| sysDoorbellEvt | input | 1 | System doorbell event pulse |
| p2sDmaDoneEvt | input | 1 | PCI-to-system DMA complete pulse |
| s2pDmaDoneEvt | input | 1 | System-to-PCI DMA complete pulse |
| sysBusErrEvt | input | 1 | System-bus error pulse |
| mstAbortEvt | input | 1 | Master abort pulse |
| tgtAbortEvt | input | 1 | Target abort pulse |
| trdyTimeoutEvt | input | 1 | TRDY timeout pulse |
| retryTimeoutEvt | input | 1 | Retry-count timeout pulse |
| rdParityErrEvt | input | 1 | Parity error on master read |
| wrPerrEvt | input | 1 | PERR# seen on master write |
| serrEvt | input | 1 | SERR# seen asserted |
| sysWrEn | input | 1 | System-side write strobe |
| sysSel | input | 1 | System-side select, 0 status, 1 enable |
| sysWrData | input | DATA_W | System-side write data |
| sysRdData | output | DATA_W | System-side read data |
| pciWrEn | input | 1 | PCI-side write strobe |
| pciSel | input | 1 | PCI-side select, 0 status, 1 enable |
| pciWrData | input | DATA_W | PCI-side write data |
| pciRdData | output | DATA_W | PCI-side read data |
| cpuIrq | output | 1 | Local processor interrupt, active high |
| pciIntN | output | 1 | PCI interrupt line, active low |

## Verification
The bench builds the block with its default bus width of 32 bits. At that width both ports carry 24 reserved bits above the eight live ones, so the checks cover zero-extension on read and the discarding of high write data. Random write data puts ones in those bits on almost every write. Random traffic often hits one status bit with a set and a clear in the same clock, and the directed cases force that collision on the doorbell bit. The directed cases also fire each fatal and parity cause alone, to show that each cause reaches its shared bit.

// File: rtl/bridge_irq_pkg.sv
`timescale 1ns/1ps
package bridge_irq_pkg;
  localparam int IRQ_N = 8;
  localparam int BIT_SERR   = 0;
  localparam int BIT_FATAL  = 1;
  localparam int BIT_PARITY = 2;
  localparam int BIT_SYSERR = 3;
  localparam int BIT_S2PDMA = 4;
  localparam int BIT_P2SDMA = 5;
  localparam int BIT_SYSDB  = 6;
  localparam int BIT_PCIDB  = 7;
  localparam logic [IRQ_N-1:0] CPU_MASK = ~(IRQ_N'(1) << BIT_PCIDB);

  typedef struct packed {
    logic [IRQ_N-1:0] setMask;
    logic [IRQ_N-1:0] clrMask;
    logic             enLoad;
    logic [IRQ_N-1:0] enData;
  } irqStrobes_t;
endpackage

// File: rtl/bridge_irq_ctrl.sv
`timescale 1ns/1ps
module bridge_irq_ctrl
  import bridge_irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FATAL_N = 4,
  parameter int PARITY_N = 2
) (
  input  logic                pciDoorbellEvt,
  input  logic                sysDoorbellEvt,
  input  logic                p2sDmaDoneEvt,
  input  logic                s2pDmaDoneEvt,
  input  logic                sysBusErrEvt,
  input  logic [FATAL_N-1:0]  fatalEvts,
  input  logic [PARITY_N-1:0] parityEvts,
  input  logic                serrEvt,
  input  logic                sysWrEn,
  input  logic                sysSel,
  input  logic [DATA_W-1:0]   sysWrData,
  input  logic                pciWrEn,
  input  logic                pciSel,
  input  logic [DATA_W-1:0]   pciWrData,
  output irqStrobes_t         strobes
);
  logic [IRQ_N-1:0] sysClr;
  logic [IRQ_N-1:0] pciClr;

  always_comb begin
    strobes.setMask = '0;
    strobes.setMask[BIT_SERR]   = serrEvt;
    strobes.setMask[BIT_FATAL]  = |fatalEvts;
    strobes.setMask[BIT_PARITY] = |parityEvts;
    strobes.setMask[BIT_SYSERR] = sysBusErrEvt;
    strobes.setMask[BIT_S2PDMA] = s2pDmaDoneEvt;
    strobes.setMask[BIT_P2SDMA] = p2sDmaDoneEvt;
    strobes.setMask[BIT_SYSDB]  = sysDoorbellEvt;
    strobes.setMask[BIT_PCIDB]  = pciDoorbellEvt;
  end

  always_comb begin
    sysClr = (sysWrEn && !sysSel) ? sysWrData[IRQ_N-1:0] : '0;
    pciClr = '0;
    pciClr[BIT_PCIDB] = pciWrEn && !pciSel && pciWrData[BIT_PCIDB];
    strobes.clrMask = sysClr | pciClr;
    strobes.enLoad  = sysWrEn && sysSel;
    strobes.enData  = sysWrData[IRQ_N-1:0];
  end
endmodule

// File: rtl/bridge_irq_datapath.sv
`timescale 1ns/1ps
module bridge_irq_datapath
  import bridge_irq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  irqStrobes_t      strobes,
  input  logic             sysSel,
  input  logic             pciSel,
  output logic [IRQ_N-1:0] statusQ,
  output logic [IRQ_N-1:0] enableQ,
  output logic [DATA_W-1:0] sysRdData,
  output logic [DATA_W-1:0] pciRdData,
  output logic             cpuIrq,
  output logic             pciIntN
);
  logic [IRQ_N-1:0] pending;
  logic [IRQ_N-1:0] sysRdRaw;
  logic [IRQ_N-1:0] pciRdRaw;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      enableQ <= '0;
    end else begin
      statusQ <= (statusQ & ~strobes.clrMask) | strobes.setMask;
      if (strobes.enLoad) enableQ <= strobes.enData;
    end
  end

  assign pending = statusQ & enableQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cpuIrq  <= 1'b0;
      pciIntN <= 1'b1;
    end else begin
      cpuIrq  <= |(pending & CPU_MASK);
      pciIntN <= ~pending[BIT_PCIDB];
    end
  end

  assign sysRdRaw = sysSel ? enableQ : statusQ;
  assign pciRdRaw = pciSel ? enableQ : statusQ;

  generate
    if (DATA_W > IRQ_N) begin : g_pad
      assign sysRdData = {{(DATA_W-IRQ_N){1'b0}}, sysRdRaw};
      assign pciRdData = {{(DATA_W-IRQ_N){1'b0}}, pciRdRaw};
    end else begin : g_exact
      assign sysRdData = sysRdRaw;
      assign pciRdData = pciRdRaw;
    end
  endgenerate
endmodule

// File: rtl/bridge_irq_agg.sv
`timescale 1ns/1ps
module bridge_irq_agg
  import bridge_irq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pciDoorbellEvt,
  input  logic              sysDoorbellEvt,
  input  logic              p2sDmaDoneEvt,
  input  logic              s2pDmaDoneEvt,
  input  logic              sysBusErrEvt,
  input  logic              mstAbortEvt,
  input  logic              tgtAbortEvt,
  input  logic              trdyTimeoutEvt,
  input  logic              retryTimeoutEvt,
  input  logic              rdParityErrEvt,
  input  logic              wrPerrEvt,
  input  logic              serrEvt,
  input  logic              sysWrEn,
  input  logic              sysSel,
  input  logic [DATA_W-1:0] sysWrData,
  output logic [DATA_W-1:0] sysRdData,
  input  logic              pciWrEn,
  input  logic              pciSel,
  input  logic [DATA_W-1:0] pciWrData,
  output logic [DATA_W-1:0] pciRdData,
  output logic              cpuIrq,
  output logic              pciIntN
);
  localparam int FATAL_N  = 4;
  localparam int PARITY_N = 2;

  irqStrobes_t      strobes;
  logic [IRQ_N-1:0] statusQ;
  logic [IRQ_N-1:0] enableQ;

  bridge_irq_ctrl #(.DATA_W(DATA_W), .FATAL_N(FATAL_N), .PARITY_N(PARITY_N)) u_ctrl (
    .pciDoorbellEvt (pciDoorbellEvt),
    .sysDoorbellEvt (sysDoorbellEvt),
    .p2sDmaDoneEvt  (p2sDmaDoneEvt),
    .s2pDmaDoneEvt  (s2pDmaDoneEvt),
    .sysBusErrEvt   (sysBusErrEvt),
    .fatalEvts      ({retryTimeoutEvt, trdyTimeoutEvt, tgtAbortEvt, mstAbortEvt}),
    .parityEvts     ({wrPerrEvt, rdParityErrEvt}),
    .serrEvt        (serrEvt),
    .sysWrEn        (sysWrEn),
    .sysSel         (sysSel),
    .sysWrData      (sysWrData),
    .pciWrEn        (pciWrEn),
    .pciSel         (pciSel),
    .pciWrData      (pciWrData),
    .strobes        (strobes)
  );

  bridge_irq_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .sysSel    (sysSel),
    .pciSel    (pciSel),
    .statusQ   (statusQ),
    .enableQ   (enableQ),
    .sysRdData (sysRdData),
    .pciRdData (pciRdData),
    .cpuIrq    (cpuIrq),
    .pciIntN   (pciIntN)
  );
endmodule

// File: rtl/bridge_irq_agg_chk.sv
`timescale 1ns/1ps
module bridge_irq_agg_chk
  import bridge_irq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              mstAbortEvt,
  input logic              tgtAbortEvt,
  input logic              trdyTimeoutEvt,
  input logic              retryTimeoutEvt,
  input logic              sysWrEn,
  input logic              pciWrEn,
  input logic [DATA_W-1:0] sysRdData,
  input logic [DATA_W-1:0] pciRdData,
  input logic [IRQ_N-1:0]  statusQ,
  input logic [IRQ_N-1:0]  enableQ,
  input logic              cpuIrq,
  input logic              pciIntN
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rstN |=> (pciIntN && !cpuIrq && statusQ == '0 && enableQ == '0));

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (sysRdData >> IRQ_N) == '0 && (pciRdData >> IRQ_N) == '0);

  assert_enable_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !sysWrEn |=> $stable(enableQ));

  assert_fatal_sets_R5: assert property (@(posedge clk) disable iff (!rstN)
    (mstAbortEvt || tgtAbortEvt || trdyTimeoutEvt || retryTimeoutEvt) |=> statusQ[BIT_FATAL]);

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!sysWrEn && !pciWrEn) |=> (($past(statusQ) & ~statusQ) == '0));

  assert_cpu_irq_R11: assert property (@(posedge clk) disable iff (!rstN)
    cpuIrq == (|($past(statusQ & enableQ) & CPU_MASK)));

  assert_pci_line_R12: assert property (@(posedge clk) disable iff (!rstN)
    pciIntN == !($past(statusQ[BIT_PCIDB] && enableQ[BIT_PCIDB])));
endmodule

bind bridge_irq_agg bridge_irq_agg_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/bridge_irq_agg_tb.sv
`timescale 1ns/1ps
module bridge_irq_agg_tb;
  localparam int DATA_W = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [11:0] evt = '0;
  logic sysWrEn = 1'b0, sysSel = 1'b0, pciWrEn = 1'b0, pciSel = 1'b0;
  logic [DATA_W-1:0] sysWrData = '0, pciWrData = '0;
  logic [DATA_W-1:0] sysRdData, pciRdData;
  logic cpuIrq, pciIntN;

  int errors = 0;
  int checks = 0;
  logic [7:0] mS = '0, mE = '0;
  logic mIrq = 1'b0, mIntN = 1'b1;

  always #2.5 clk = ~clk;

  bridge_irq_agg #(.DATA_W(DATA_W)) u_dut (
    .clk(clk), .rstN(rstN),
    .pciDoorbellEvt(evt[11]), .sysDoorbellEvt(evt[10]), .p2sDmaDoneEvt(evt[9]),
    .s2pDmaDoneEvt(evt[8]), .sysBusErrEvt(evt[7]), .mstAbortEvt(evt[1]),
    .tgtAbortEvt(evt[2]), .trdyTimeoutEvt(evt[3]), .retryTimeoutEvt(evt[4]),
    .rdParityErrEvt(evt[5]), .wrPerrEvt(evt[6]), .serrEvt(evt[0]),
    .sysWrEn(sysWrEn), .sysSel(sysSel), .sysWrData(sysWrData), .sysRdData(sysRdData),
    .pciWrEn(pciWrEn), .pciSel(pciSel), .pciWrData(pciWrData), .pciRdData(pciRdData),
    .cpuIrq(cpuIrq), .pciIntN(pciIntN)
  );

  function automatic logic [7:0] setOf(logic [11:0] e);
    return {e[11], e[10], e[9], e[8], e[7], |e[6:5], |e[4:1], e[0]};
  endfunction

  function automatic logic [7:0] clrOf(logic sw, logic ss, logic [DATA_W-1:0] sd,
                                       logic pw, logic ps, logic [DATA_W-1:0] pd);
    logic [7:0] c = (sw && !ss) ? sd[7:0] : 8'h00;
    if (pw && !ps && pd[7]) c[7] = 1'b1;
    return c;
  endfunction

  task automatic check(input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compareAll();
    check(32'(cpuIrq), 32'(mIrq), "R11 cpuIrq");
    check(32'(pciIntN), 32'(mIntN), "R12 pciIntN");
    check(sysRdData, {24'h0, sysSel ? mE : mS}, "R4 sys read");
    check(pciRdData, {24'h0, pciSel ? mE : mS}, "R3 pci read");
  endtask

  task automatic tick();
    @(posedge clk);
    mIrq  = |(mS & mE & 8'h7f);
    mIntN = !(mS[7] && mE[7]);
    mS = (mS & ~clrOf(sysWrEn, sysSel, sysWrData, pciWrEn, pciSel, pciWrData)) | setOf(evt);
    if (sysWrEn && sysSel) mE = sysWrData[7:0];
    @(negedge clk);
    compareAll();
    evt = '0; sysWrEn = 1'b0; pciWrEn = 1'b0;
  endtask

  task automatic sysWrite(input logic sel, input logic [DATA_W-1:0] d);
    sysWrEn = 1'b1; sysSel = sel; sysWrData = d;
  endtask

  task automatic pciWrite(input logic sel, input logic [DATA_W-1:0] d);
    pciWrEn = 1'b1; pciSel = sel; pciWrData = d;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(32'(cpuIrq), 0, "R1 cpuIrq in reset");
    check(32'(pciIntN), 1, "R1 pciIntN in reset");
    sysSel = 1'b0; pciSel = 1'b1;
    check(sysRdData, 0, "R1 status in reset");
    check(pciRdData, 0, "R1 enable in reset");
    rstN = 1'b1;

    sysWrite(1'b1, 32'hFFFF_FFA5); tick();
    sysSel = 1'b1; #0.1;
    check(sysRdData, 32'h0000_00A5, "R2 enable load and reserved");
    pciWrite(1'b1, 32'h0000_005A); tick();
    check(pciRdData, 32'h0000_00A5, "R3 pci enable write ignored");

    sysSel = 1'b0;
    for (int i = 1; i <= 4; i++) begin
      sysWrite(1'b0, 32'hFF); tick();
      evt = 12'(1) << i; tick();
      check(sysRdData, 32'h02, "R5 fatal cause");
    end
    for (int i = 5; i <= 6; i++) begin
      sysWrite(1'b0, 32'hFF); tick();
      evt = 12'(1) << i; tick();
      check(sysRdData, 32'h04, "R6 parity cause");
    end
    sysWrite(1'b0, 32'hFF); tick();
    evt = 12'h001; tick();
    check(sysRdData, 32'h01, "R7 serr");

    evt = 12'hFFF; tick();
    check(sysRdData, 32'hFF, "R4 all events set");
    sysWrite(1'b0, 32'hFFFF_FF00); tick();
    check(sysRdData, 32'hFF, "R8 zeros keep bits");
    sysWrite(1'b0, 32'h0F); tick();
    check(sysRdData, 32'hF0, "R8 ones clear bits");

    pciWrite(1'b0, 32'h7F); tick();
    check(sysRdData, 32'hF0, "R9 pci low bits ignored");
    pciWrite(1'b0, 32'h80); tick();
    check(sysRdData, 32'h70, "R9 pci clears doorbell");

    evt = 12'h800; sysWrite(1'b0, 32'h80); pciWrite(1'b0, 32'h80); tick();
    check(sysRdData, 32'hF0, "R10 set wins");

    sysWrite(1'b1, 32'h80); tick();
    tick();
    check(32'(pciIntN), 0, "R12 doorbell drives line");
    check(32'(cpuIrq), 0, "R12 doorbell not on cpuIrq");
    sysWrite(1'b1, 32'h81); tick();
    evt = 12'h001; tick();
    check(32'(cpuIrq), 0, "R11 one clock latency");
    tick();
    check(32'(cpuIrq), 1, "R11 cpuIrq raised");

    for (int n = 0; n < 2000; n++) begin
      for (int b = 0; b < 12; b++) evt[b] = ($urandom % 12) == 0;
      sysSel = $urandom % 2; pciSel = $urandom % 2;
      sysWrEn = ($urandom % 4) == 0; pciWrEn = ($urandom % 4) == 0;
      sysWrData = $urandom; pciWrData = $urandom;
      tick();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule